// File: doc/BRIEF.md
# Exception Escalation Controller

This block sits between a processor's fault detection logic and its exception entry sequencer. It receives exception requests, each carrying a vector number and an error code. It decides which vector the entry sequencer must deliver next. While a handler is being invoked, the core raises an invocation-busy flag. During that window the core also reports, through a handler-present bit, whether the descriptor table holds a valid entry for the vector being delivered. A completion pulse marks the end of each delivery.

A fault raised during the invocation window is checked against a fixed pairing table. A qualifying pair, or a missing handler, escalates to a double fault (vector 8, error code zero). A further fault, or a missing handler, while the double-fault handler is being invoked escalates to a triple fault. A triple fault cannot be handled: it raises a sticky reset request that only the block's reset clears. A fault that does not qualify is held in a small in-order queue and is delivered after the current delivery completes.

Top module: `exc_escalate`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `dlv_valid`, `dlv_double` and `shutdown_req` are low, the block is idle and the pending queue is empty. A reset also clears a latched shutdown.
- R2: In the idle state, `exc_valid` causes a one-cycle `dlv_valid` pulse on the next clock edge, with `dlv_vector` and `dlv_err` equal to the request's vector and error code.
- R3: While a normal delivery is busy (`inv_busy` high), a new request escalates to a double fault when the vector being delivered is 0, 10, 11, 12 or 13 and the new vector is 10, 11, 12 or 13.
- R4: While a normal delivery of vector 14 is busy, a new request with vector 10, 11, 12, 13 or 14 escalates to a double fault.
- R5: While a normal delivery is busy and `hdl_present` is low, the block escalates to a double fault on the next edge, whether or not a request arrives.
- R6: A double fault is delivered as a `dlv_valid` pulse with `dlv_double` high, `dlv_vector` = 8 and `dlv_err` = 0. A request that arrives in the escalating cycle is consumed by the escalation and is not queued.
- R7: While a double-fault delivery is busy, a request or a low `hdl_present` sets `shutdown_req` on the next edge. Once set, it stays high and no further `dlv_valid` pulse occurs until reset.
- R8: A request that does not escalate while a delivery is in progress is queued. Each `dlv_done` then delivers the oldest queued request, in arrival order.
- R9: The queue holds `PEND_DEPTH` (default 4) requests. A request that arrives while it is full, with no `dlv_done` in the same cycle, is dropped.
- R10: A `dlv_done` with an empty queue returns the block to idle with no `dlv_valid` pulse. The next request is then handled as a first exception, without escalation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Exception request strobe |
| exc_vector | input | VW | Vector of the request |
| exc_err | input | EW | Error code of the request |
| inv_busy | input | 1 | Handler invocation currently in progress |
| hdl_present | input | 1 | Descriptor entry valid for the vector being delivered |
| dlv_done | input | 1 | Current delivery has completed |
| dlv_valid | output | 1 | One-cycle pulse: deliver `dlv_vector` now |
| dlv_vector | output | VW | Vector to deliver |
| dlv_err | output | EW | Error code to push with the delivery |
| dlv_double | output | 1 | Delivery is a double fault |
| shutdown_req | output | 1 | Sticky triple-fault reset request |

## Verification
On every cycle, the bound checker enforces the shape of a double-fault delivery: vector 8, zero error code and a coincident valid pulse. It also enforces that a missing handler during a busy first delivery always leads to a double fault. The shutdown request is checked to stay latched, to block deliveries, and to follow any fault raised during a busy double-fault delivery. The pairing table itself, the arrival order of queued exceptions, the dropping at a full queue and the return to idle can only be shown by the bench's scenarios. These scenarios walk a table of exception pairs and then run directed sequences.

// File: rtl/exc_escalate_pkg.sv
package exc_escalate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_DOUBLE = 2'd2,
    ST_TRIPLE = 2'd3
  } esc_state_t;

  localparam int unsigned VEC_DIVIDE  = 0;
  localparam int unsigned VEC_DOUBLE  = 8;
  localparam int unsigned VEC_BAD_TSS = 10;
  localparam int unsigned VEC_SEG_NP  = 11;
  localparam int unsigned VEC_STACK   = 12;
  localparam int unsigned VEC_GENPROT = 13;
  localparam int unsigned VEC_PAGE    = 14;

endpackage

// File: rtl/exc_pair_check.sv
module exc_pair_check
  import exc_escalate_pkg::*;
#(
  parameter int unsigned VW = 8
) (
  input  logic [VW-1:0] first_vec,
  input  logic [VW-1:0] second_vec,
  output logic          escalate
);

  logic first_contrib;
  logic first_page;
  logic second_contrib;
  logic second_page;

  always_comb begin
    second_contrib = (second_vec == VW'(VEC_BAD_TSS)) || (second_vec == VW'(VEC_SEG_NP)) ||
                     (second_vec == VW'(VEC_STACK))   || (second_vec == VW'(VEC_GENPROT));
    second_page    = (second_vec == VW'(VEC_PAGE));
    first_contrib  = (first_vec == VW'(VEC_DIVIDE))  || (first_vec == VW'(VEC_BAD_TSS)) ||
                     (first_vec == VW'(VEC_SEG_NP))  || (first_vec == VW'(VEC_STACK))   ||
                     (first_vec == VW'(VEC_GENPROT));
    first_page     = (first_vec == VW'(VEC_PAGE));
    escalate       = (first_contrib && second_contrib) ||
                     (first_page && (second_contrib || second_page));
  end

endmodule

// File: rtl/exc_pend_fifo.sv
module exc_pend_fifo #(
  parameter int unsigned W     = 24,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (cnt_q == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && ((cnt_q != CW'(DEPTH)) || do_pop);
  assign head    = mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/exc_escalate.sv
module exc_escalate
  import exc_escalate_pkg::*;
#(
  parameter int unsigned VW         = 8,
  parameter int unsigned EW         = 16,
  parameter int unsigned PEND_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exc_valid,
  input  logic [VW-1:0] exc_vector,
  input  logic [EW-1:0] exc_err,
  input  logic          inv_busy,
  input  logic          hdl_present,
  input  logic          dlv_done,
  output logic          dlv_valid,
  output logic [VW-1:0] dlv_vector,
  output logic [EW-1:0] dlv_err,
  output logic          dlv_double,
  output logic          shutdown_req
);

  localparam int unsigned QW = VW + EW;

  esc_state_t    state_q;
  logic [VW-1:0] cur_vec_q;

  logic          pair_hit;
  logic          in_delivery;
  logic          go_triple, go_double, take_idle, finishing;
  logic          bypass, q_push, q_pop, q_empty;
  logic [QW-1:0] q_head;
  logic [VW-1:0] head_vec;
  logic [EW-1:0] head_err;

  exc_pair_check #(.VW(VW)) u_pair (
    .first_vec  (cur_vec_q),
    .second_vec (exc_vector),
    .escalate   (pair_hit)
  );

  exc_pend_fifo #(.W(QW), .DEPTH(PEND_DEPTH)) u_pend (
    .clk   (clk),
    .rst   (rst),
    .push  (q_push),
    .din   ({exc_vector, exc_err}),
    .pop   (q_pop),
    .head  (q_head),
    .empty (q_empty)
  );

  assign {head_vec, head_err} = q_head;

  always_comb begin
    in_delivery = (state_q == ST_FIRST) || (state_q == ST_DOUBLE);
    go_triple   = (state_q == ST_DOUBLE) && inv_busy && (exc_valid || !hdl_present);
    go_double   = (state_q == ST_FIRST) && inv_busy &&
                  ((exc_valid && pair_hit) || !hdl_present);
    take_idle   = (state_q == ST_IDLE) && exc_valid;
    finishing   = in_delivery && dlv_done && !go_triple && !go_double;
    bypass      = finishing && q_empty && exc_valid;
    q_pop       = finishing && !q_empty;
    q_push      = exc_valid && in_delivery && !go_triple && !go_double && !bypass;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      cur_vec_q    <= '0;
      dlv_valid    <= 1'b0;
      dlv_vector   <= '0;
      dlv_err      <= '0;
      dlv_double   <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      dlv_valid  <= 1'b0;
      dlv_double <= 1'b0;
      if (state_q == ST_TRIPLE) begin
        shutdown_req <= 1'b1;
      end else if (go_triple) begin
        state_q      <= ST_TRIPLE;
        shutdown_req <= 1'b1;
      end else if (go_double) begin
        state_q    <= ST_DOUBLE;
        cur_vec_q  <= VW'(VEC_DOUBLE);
        dlv_valid  <= 1'b1;
        dlv_double <= 1'b1;
        dlv_vector <= VW'(VEC_DOUBLE);
        dlv_err    <= '0;
      end else if (take_idle || bypass) begin
        state_q    <= ST_FIRST;
        cur_vec_q  <= exc_vector;
        dlv_valid  <= 1'b1;
        dlv_vector <= exc_vector;
        dlv_err    <= exc_err;
      end else if (q_pop) begin
        state_q    <= ST_FIRST;
        cur_vec_q  <= head_vec;
        dlv_valid  <= 1'b1;
        dlv_vector <= head_vec;
        dlv_err    <= head_err;
      end else if (finishing) begin
        state_q <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/exc_escalate_chk.sv
module exc_escalate_chk
  import exc_escalate_pkg::*;
#(
  parameter int unsigned VW = 8,
  parameter int unsigned EW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          exc_valid,
  input logic          inv_busy,
  input logic          hdl_present,
  input logic          dlv_valid,
  input logic [VW-1:0] dlv_vector,
  input logic [EW-1:0] dlv_err,
  input logic          dlv_double,
  input logic          shutdown_req,
  input esc_state_t    state_q
);

  // R6: a double fault always carries vector 8 and a zero error code
  p_df_shape_r6: assert property (@(posedge clk) disable iff (rst)
    dlv_double |-> (dlv_valid && dlv_vector == VW'(VEC_DOUBLE) && dlv_err == '0));

  // R5: a missing handler during a busy first delivery escalates
  p_missing_handler_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FIRST && inv_busy && !hdl_present) |=> dlv_double);

  // R7: any fault during a busy double-fault delivery shuts down
  p_triple_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DOUBLE && inv_busy && (exc_valid || !hdl_present)) |=> shutdown_req);

  // R7: the shutdown request stays latched
  p_shutdown_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    shutdown_req |=> shutdown_req);

  // R7: nothing is delivered once shut down
  p_no_dlv_in_shutdown_r7: assert property (@(posedge clk) disable iff (rst)
    shutdown_req |-> !dlv_valid);

endmodule

bind exc_escalate exc_escalate_chk #(.VW(VW), .EW(EW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .exc_valid    (exc_valid),
  .inv_busy     (inv_busy),
  .hdl_present  (hdl_present),
  .dlv_valid    (dlv_valid),
  .dlv_vector   (dlv_vector),
  .dlv_err      (dlv_err),
  .dlv_double   (dlv_double),
  .shutdown_req (shutdown_req),
  .state_q      (state_q)
);

// File: tb/exc_escalate_tb.sv
module exc_escalate_tb;

  localparam int VW = 8;
  localparam int EW = 16;
  localparam int NPAIR = 10;
  // {first vector, second vector, expect double fault}
  localparam logic [16:0] PAIRS [NPAIR] = '{
    {8'd0,  8'd13, 1'b1}, {8'd0,  8'd14, 1'b0}, {8'd0,  8'd0,  1'b0},
    {8'd10, 8'd12, 1'b1}, {8'd13, 8'd11, 1'b1}, {8'd14, 8'd14, 1'b1},
    {8'd14, 8'd10, 1'b1}, {8'd14, 8'd0,  1'b0}, {8'd12, 8'd14, 1'b0},
    {8'd11, 8'd3,  1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic exc_valid = 1'b0;
  logic [VW-1:0] exc_vector = '0;
  logic [EW-1:0] exc_err = '0;
  logic inv_busy = 1'b0;
  logic hdl_present = 1'b1;
  logic dlv_done = 1'b0;
  logic dlv_valid, dlv_double, shutdown_req;
  logic [VW-1:0] dlv_vector;
  logic [EW-1:0] dlv_err;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  exc_escalate #(.VW(VW), .EW(EW), .PEND_DEPTH(4)) u_dut (
    .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_vector(exc_vector),
    .exc_err(exc_err), .inv_busy(inv_busy), .hdl_present(hdl_present),
    .dlv_done(dlv_done), .dlv_valid(dlv_valid), .dlv_vector(dlv_vector),
    .dlv_err(dlv_err), .dlv_double(dlv_double), .shutdown_req(shutdown_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle of inputs, then sample after the edge
  task automatic step(input bit v, input int vec, input int err,
                      input bit busy, input bit pres, input bit done);
    exc_valid = v; exc_vector = VW'(vec); exc_err = EW'(err);
    inv_busy = busy; hdl_present = pres; dlv_done = done;
    @(negedge clk);
    exc_valid = 0; inv_busy = 0; hdl_present = 1; dlv_done = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic expect_dlv(input string req, input int vec);
    chk(dlv_valid == 1'b1, req, dlv_valid, 1);
    chk(dlv_vector == VW'(vec), req, dlv_vector, vec);
  endtask

  task automatic expect_df(input string req);
    chk(dlv_valid && dlv_double, req, dlv_double, 1);
    chk(dlv_vector == 8 && dlv_err == 0, req, dlv_vector, 8);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(!dlv_valid && !dlv_double && !shutdown_req, "R1", shutdown_req, 0);

    // Pair table walk: R3 / R4 / R8
    for (int i = 0; i < NPAIR; i++) begin
      int f, s;
      bit df;
      f = PAIRS[i][16:9]; s = PAIRS[i][8:1]; df = PAIRS[i][0];
      do_reset();
      step(1, f, 100 + i, 0, 1, 0);
      expect_dlv("R2", f);
      step(1, s, 7, 1, 1, 0);
      if (df) begin
        expect_df((f == 14) ? "R4" : "R3");
      end else begin
        chk(!dlv_valid, (f == 14) ? "R4" : "R3", dlv_valid, 0);
        step(0, 0, 0, 0, 1, 1);
        expect_dlv("R8", s);
      end
    end

    // R2 error code passes through; R5 missing handler; R6 zero code
    do_reset();
    step(1, 13, 16'h5A5A, 0, 1, 0);
    chk(dlv_err == 16'h5A5A, "R2", dlv_err, 16'h5A5A);
    step(0, 0, 0, 1, 0, 0);
    expect_df("R5");
    chk(dlv_err == 0, "R6", dlv_err, 0);
    // R7 fault during busy double fault delivery
    step(1, 14, 3, 1, 1, 0);
    chk(shutdown_req == 1, "R7", shutdown_req, 1);
    chk(!dlv_valid, "R7", dlv_valid, 0);
    step(1, 0, 0, 0, 1, 1);
    chk(shutdown_req && !dlv_valid, "R7", dlv_valid, 0);
    step(1, 3, 0, 0, 1, 1);
    chk(shutdown_req && !dlv_valid, "R7", shutdown_req, 1);
    do_reset();
    chk(!shutdown_req, "R1", shutdown_req, 0);

    // R7 missing double fault handler
    step(1, 14, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0, 0);
    expect_df("R5");
    step(0, 0, 0, 1, 0, 0);
    chk(shutdown_req == 1, "R7", shutdown_req, 1);

    // R6 concurrent request consumed by escalation; R10 back to idle
    do_reset();
    step(1, 14, 0, 0, 1, 0);
    step(1, 13, 9, 1, 1, 0);
    expect_df("R6");
    step(0, 0, 0, 0, 1, 1);
    chk(!dlv_valid, "R6", dlv_valid, 0);
    step(1, 13, 4, 1, 1, 0);
    expect_dlv("R10", 13);
    chk(!dlv_double, "R10", dlv_double, 0);

    // R8 arrival order, R9 full queue drops, R10 idle after drain
    do_reset();
    step(1, 1, 0, 0, 1, 0);
    expect_dlv("R2", 1);
    for (int v = 2; v <= 6; v++) step(1, v, v, 0, 1, 0);
    for (int v = 2; v <= 5; v++) begin
      step(0, 0, 0, 0, 1, 1);
      expect_dlv("R8", v);
      chk(dlv_err == EW'(v), "R8", dlv_err, v);
    end
    step(0, 0, 0, 0, 1, 1);
    chk(!dlv_valid, "R9", dlv_valid, 0);
    step(1, 0, 0, 0, 1, 0);
    expect_dlv("R10", 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule